// File: doc/BRIEF.md
# Interrupt Line State Bank

This block keeps the per-line state for a configurable number of external interrupt lines. Each line has three bits: an enable bit, a pending bit and an active bit. Software reaches them through a small register bus. Enable and pending each have two addresses. Writing ones to the set address turns those bits on. Writing ones to the clear address turns them off. Either address reads back the current state. The active bits are read-only.

The core side drives the hardware events. A level input on an enabled line latches its pending bit. An acknowledge for a line marks it active and drops its pending bit. An exception return for a line clears its active bit. Active bits stay set while a handler is preempted, so several lines can be active at once. A read-only type word gives the number of implemented lines in units of 32. The block outputs the vector of lines that are both pending and enabled, for an arbiter that sits outside it.

Address layout: `bus_addr` is {group[2:0], word}, where the word field is wide enough to index ceil(NUM_LINES/32) words. Word w of a group covers lines 32w to 32w+31, with bit b of the data standing for line 32w+b. The groups are: 0 for type, 1 for enable-set, 2 for enable-clear, 3 for pending-set, 4 for pending-clear and 5 for active. Groups 6 and 7 read zero.

Top module: `irq_state_bank`

## Requirements
- R1: After a synchronous active-low reset, every enable, pending and active bit is 0. Reads of all groups except type return 0, and `irq_req` is 0.
- R2: A write to enable-set (group 1) sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. A write of zero changes nothing. Reading group 1 or group 2 returns the enable bits.
- R3: A write to enable-clear (group 2) clears each enable bit whose data bit is 1 and leaves the others unchanged. A write of zero changes nothing.
- R4: Writes to pending-set (group 3) and pending-clear (group 4) set and clear pending bits in the same way as R2 and R3. Reading group 3 or group 4 returns the pending bits.
- R5: If `irq_in[i]` is 1 at a clock edge while line i is enabled, pending bit i is 1 after that edge. If line i is disabled, the input leaves pending bit i unchanged.
- R6: An acknowledge (`ack_valid` with `ack_line`=i) sets active bit i and clears pending bit i at the next edge. A return (`ret_valid` with `ret_line`=i) clears active bit i.
- R7: An acknowledge for a second line leaves the active bit of a line already active at 1 (preemption). That bit stays at 1 until a return for that line.
- R8: A line can be active and pending at the same time. In that state, reading group 5 returns 1 for that line and reading group 3 returns 1 for it as well.
- R9: Group 0, word 0 returns ceil(NUM_LINES/32)-1 in bits [4:0] and 0 in the other bits. Group 0 at any other word returns 0.
- R10: Data bits for lines at or above NUM_LINES read as 0 and ignore writes. An acknowledge for a line number at or above NUM_LINES has no effect.
- R11: `bus_rvalid` is 1 for exactly the cycle after a cycle with `bus_rd`=1. In that cycle `bus_rdata` holds the addressed word. Otherwise `bus_rvalid` is 0.
- R12: `irq_req[i]` is the AND of pending bit i and enable bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | {group, word} address |
| bus_wdata | input | 32 | Write data, one bit per line of the word |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq_in | input | NUM_LINES | Level interrupt inputs |
| ack_valid | input | 1 | Core enters a handler |
| ack_line | input | IDX_W | Line being entered |
| ret_valid | input | 1 | Core executes an exception return |
| ret_line | input | IDX_W | Line being returned from |
| irq_req | output | NUM_LINES | Lines that are pending and enabled |

## Verification
The assertions check the following on every cycle:
- an acknowledge makes its line active and drops its pending bit;
- a return clears the line's active bit;
- an active bit holds unless its line returns;
- an enabled, asserted input latches pending unless a clear or an acknowledge competes in the same cycle;
- the read-valid strobe follows the read strobe.

Other behaviour is shown only by the bench scenarios:
- the bit-selective effect of set and clear writes;
- the equality of the two read aliases;
- the preemption sequence in which two lines are active together;
- the active-and-pending overlap;
- the type word;
- the masking of bits above the implemented line count.

// File: rtl/irq_bank_pkg.sv
// Package: shared address group codes and size helpers for the interrupt
// line state bank. Assumes 32 lines per bus word.
package irq_bank_pkg;

    localparam int LINES_PER_WORD = 32;

    typedef enum logic [2:0] {
        GRP_TYPE    = 3'd0,
        GRP_EN_SET  = 3'd1,
        GRP_EN_CLR  = 3'd2,
        GRP_PD_SET  = 3'd3,
        GRP_PD_CLR  = 3'd4,
        GRP_ACTIVE  = 3'd5,
        GRP_RSVD6   = 3'd6,
        GRP_RSVD7   = 3'd7
    } grp_e;

    // Number of bus words needed to hold n lines.
    function automatic int words_for(input int n);
        return (n + LINES_PER_WORD - 1) / LINES_PER_WORD;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
// Module: turns a bus write into per-line set and clear strobes for the
// enable and pending bits. Assumes bus_wr is a single-cycle strobe. Lines
// that do not exist get no strobe, so writes to them are dropped.
module irq_bus_decode
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 40,
    parameter int WORD_W    = 1,
    parameter int ADDR_W    = 4
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [NUM_LINES-1:0] en_set,
    output logic [NUM_LINES-1:0] en_clr,
    output logic [NUM_LINES-1:0] pd_set,
    output logic [NUM_LINES-1:0] pd_clr
);

    grp_e              grp;
    logic [WORD_W-1:0] word;

    // Split the address into group and word fields.
    always_comb begin
        grp  = grp_e'(bus_addr[ADDR_W-1 -: 3]);
        word = bus_addr[WORD_W-1:0];
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int W = i / LINES_PER_WORD;
        localparam int B = i % LINES_PER_WORD;
        logic hit;
        // The strobe for line i fires only when its word is addressed and its data bit is 1.
        assign hit       = bus_wr && (word == WORD_W'(W)) && bus_wdata[B];
        assign en_set[i] = hit && (grp == GRP_EN_SET);
        assign en_clr[i] = hit && (grp == GRP_EN_CLR);
        assign pd_set[i] = hit && (grp == GRP_PD_SET);
        assign pd_clr[i] = hit && (grp == GRP_PD_CLR);
    end

endmodule

// File: rtl/irq_line_bank.sv
// Module: per-line enable, pending and active flops. Assumes acknowledge and
// return each name one line per cycle. If an acknowledge and a return name
// the same line in the same cycle, the acknowledge wins. Clears win over sets
// for pending.
module irq_line_bank #(
    parameter int NUM_LINES = 40,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    input  logic                 ret_valid,
    input  logic [IDX_W-1:0]     ret_line,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    input  logic [NUM_LINES-1:0] pd_set,
    input  logic [NUM_LINES-1:0] pd_clr,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pd_q,
    output logic [NUM_LINES-1:0] act_q
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic ack_hit;
        logic ret_hit;
        assign ack_hit = ack_valid && (ack_line == IDX_W'(i));
        assign ret_hit = ret_valid && (ret_line == IDX_W'(i));

        // Update the enable, pending and active state of line i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[i]  <= 1'b0;
                pd_q[i]  <= 1'b0;
                act_q[i] <= 1'b0;
            end else begin
                en_q[i]  <= (en_q[i] | en_set[i]) & ~en_clr[i];
                pd_q[i]  <= (pd_q[i] | pd_set[i] | (irq_in[i] & en_q[i])) & ~(pd_clr[i] | ack_hit);
                act_q[i] <= ack_hit | (act_q[i] & ~ret_hit);
            end
        end

        // R5: an enabled, asserted input latches pending when nothing clears it
        p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[i] && en_q[i] && !pd_clr[i] && !(ack_valid && ack_line == IDX_W'(i)))
            |=> pd_q[i]);

        // R6: handler entry marks the line active and drops its pending bit
        p_ack_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_line == IDX_W'(i)) |=> (act_q[i] && !pd_q[i]));

        // R6: exception return clears the active bit
        p_ret_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_valid && ret_line == IDX_W'(i) && !(ack_valid && ack_line == IDX_W'(i)))
            |=> !act_q[i]);

        // R7: an active line stays active through preemption until its own return
        p_hold_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (act_q[i] && !(ret_valid && ret_line == IDX_W'(i))) |=> act_q[i]);
    end

endmodule

// File: rtl/irq_read_port.sv
// Module: registered read mux for the bank. Assumes bus_rd is a
// single-cycle strobe. Data appears with rvalid in the following cycle.
// Words and bits beyond the implemented lines read zero.
module irq_read_port
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 40,
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 1,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic [NUM_LINES-1:0] pd_q,
    input  logic [NUM_LINES-1:0] act_q,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid
);

    localparam int PAD_W = NUM_WORDS * LINES_PER_WORD;

    logic [PAD_W-1:0] en_pad;
    logic [PAD_W-1:0] pd_pad;
    logic [PAD_W-1:0] act_pad;
    logic [31:0]      rd_mux;
    grp_e             grp;
    int               widx;

    assign en_pad  = PAD_W'(en_q);
    assign pd_pad  = PAD_W'(pd_q);
    assign act_pad = PAD_W'(act_q);

    // Select the addressed word of the addressed group.
    always_comb begin
        grp    = grp_e'(bus_addr[ADDR_W-1 -: 3]);
        widx   = int'(bus_addr[WORD_W-1:0]);
        rd_mux = '0;
        if (widx < NUM_WORDS) begin
            case (grp)
                GRP_TYPE:               rd_mux = (widx == 0) ? 32'(NUM_WORDS - 1) & 32'h1F : 32'd0;
                GRP_EN_SET, GRP_EN_CLR: rd_mux = en_pad[widx*LINES_PER_WORD +: LINES_PER_WORD];
                GRP_PD_SET, GRP_PD_CLR: rd_mux = pd_pad[widx*LINES_PER_WORD +: LINES_PER_WORD];
                GRP_ACTIVE:             rd_mux = act_pad[widx*LINES_PER_WORD +: LINES_PER_WORD];
                default:                rd_mux = '0;
            endcase
        end
    end

    // Register the read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    // R11: a read strobe produces exactly one valid cycle right after it
    p_rvalid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    p_rvalid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

endmodule

// File: rtl/irq_state_bank.sv
// Module: top of the interrupt line state bank. It joins the write decoder,
// the per-line state flops and the registered read port. It also exports
// the pending-and-enabled vector for an external arbiter. Assumes one
// bus access per cycle at most.
module irq_state_bank
    import irq_bank_pkg::*;
#(
    parameter int   NUM_LINES = 40,
    localparam int  NUM_WORDS = words_for(NUM_LINES),
    localparam int  WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int  ADDR_W    = 3 + WORD_W,
    localparam int  IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    input  logic                 ret_valid,
    input  logic [IDX_W-1:0]     ret_line,
    output logic [NUM_LINES-1:0] irq_req
);

    logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_LINES-1:0] en_q, pd_q, act_q;

    irq_bus_decode #(
        .NUM_LINES (NUM_LINES),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr)
    );

    irq_line_bank #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .ret_valid (ret_valid),
        .ret_line  (ret_line),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr),
        .en_q      (en_q),
        .pd_q      (pd_q),
        .act_q     (act_q)
    );

    irq_read_port #(
        .NUM_LINES (NUM_LINES),
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W)
    ) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .en_q       (en_q),
        .pd_q       (pd_q),
        .act_q      (act_q),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    // R12: request vector offered to the arbiter
    assign irq_req = pd_q & en_q;

endmodule

// File: tb/sim_irq_state_bank.sv
`timescale 1ns/1ps
// Scoreboard bench. The read driver pushes the expected word from a bench
// model into a queue. A monitor pops it and compares when bus_rvalid appears.
module sim_irq_state_bank;

    localparam int N    = 40;
    localparam int NW   = 2;
    localparam int AW   = 4;
    localparam int IW   = 6;
    localparam logic [63:0] LMASK = (64'd1 << N) - 64'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [N-1:0]  irq_in = '0;
    logic          ack_valid = 1'b0, ret_valid = 1'b0;
    logic [IW-1:0] ack_line = '0, ret_line = '0;
    logic [N-1:0]  irq_req;

    int  total = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    logic [63:0] en_m = '0, pd_m = '0, ac_m = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_state_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_in(irq_in), .ack_valid(ack_valid),
        .ack_line(ack_line), .ret_valid(ret_valid), .ret_line(ret_line),
        .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each returned read word with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rvalid", 64'(bus_rdata), 64'hDEAD);
            end else begin
                check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic bwrite(input int grp, input int word, input logic [31:0] data);
        logic [63:0] m;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {3'(grp), 1'(word)}; bus_wdata = data;
        m = (64'(data) << (32 * word)) & LMASK;
        case (grp)
            1: en_m = en_m | m;
            2: en_m = en_m & ~m;
            3: pd_m = pd_m | m;
            4: pd_m = pd_m & ~m;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input int grp, input int word, input string tag);
        logic [63:0] v;
        case (grp)
            0: v = (word == 0) ? 64'(NW - 1) : 64'd0;
            1, 2: v = en_m;
            3, 4: v = pd_m;
            5: v = ac_m;
            default: v = 64'd0;
        endcase
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = {3'(grp), 1'(word)};
        exp_q.push_back(32'(v >> (32 * word)));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_irq(input int idx);
        @(negedge clk);
        irq_in[idx] = 1'b1;
        if (en_m[idx]) pd_m[idx] = 1'b1;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic do_ack(input int idx);
        @(negedge clk);
        ack_valid = 1'b1; ack_line = IW'(idx);
        if (idx < N) begin ac_m[idx] = 1'b1; pd_m[idx] = 1'b0; end
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic do_ret(input int idx);
        @(negedge clk);
        ret_valid = 1'b1; ret_line = IW'(idx);
        if (idx < N) ac_m[idx] = 1'b0;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic check_req(input string tag);
        @(negedge clk);
        check(tag, 64'(irq_req), (pd_m & en_m));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        bread(1, 0, "R1 enable w0 after reset");
        bread(2, 1, "R1 enable w1 after reset");
        bread(3, 0, "R1 pending after reset");
        bread(5, 0, "R1 active w0 after reset");
        bread(5, 1, "R1 active w1 after reset");
        check_req("R1 irq_req after reset");
        // R9 type word
        bread(0, 0, "R9 type word code");
        bread(0, 1, "R9 type group other word");
        // R2 enable set, both aliases, zero write
        bwrite(1, 0, 32'h0000_00F1);
        bread(1, 0, "R2 enable set alias");
        bread(2, 0, "R2 enable clear alias read");
        bwrite(1, 0, 32'h0);
        bread(1, 0, "R2 zero write no effect");
        // R10 bits beyond line count
        bwrite(1, 1, 32'hFFFF_FFFF);
        bread(1, 1, "R10 enable upper bits read zero");
        // R3 enable clear
        bwrite(2, 0, 32'h0000_0001);
        bread(1, 0, "R3 enable clear one bit");
        bwrite(2, 0, 32'h0);
        bread(2, 0, "R3 zero clear no effect");
        // R4 pending set and clear
        bwrite(3, 0, 32'h0000_0300);
        bread(3, 0, "R4 pending set alias");
        bread(4, 0, "R4 pending clear alias read");
        bwrite(4, 0, 32'h0000_0100);
        bread(3, 0, "R4 pending clear one bit");
        // R12 request vector
        bwrite(3, 1, 32'h0000_0001);
        check_req("R12 irq_req pending and enabled");
        // R5 hardware latch: line 4 enabled, line 2 disabled
        pulse_irq(4);
        pulse_irq(2);
        bread(3, 0, "R5 latch enabled only");
        // R6 acknowledge and return
        do_ack(4);
        bread(5, 0, "R6 ack sets active");
        bread(3, 0, "R6 ack clears pending");
        // R7 preemption
        do_ack(5);
        bread(5, 0, "R7 two lines active");
        do_ret(5);
        bread(5, 0, "R7 preempted line stays active");
        // R8 active and pending
        bwrite(3, 0, 32'h0000_0010);
        bread(5, 0, "R8 active while pending");
        bread(3, 0, "R8 pending while active");
        do_ret(4);
        bread(5, 0, "R6 return clears active");
        // R10 acknowledge beyond line count ignored
        do_ack(36);
        do_ack(45);
        bread(5, 1, "R10 out of range ack ignored");
        do_ret(36);
        bread(5, 1, "R6 return upper word");
        // R11 no rvalid without a read
        @(negedge clk);
        check("R11 rvalid idle", 64'(bus_rvalid), 64'd0);
        check("R11 queue drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule